// File: doc/BRIEF.md
# Effective Address Decoder for ModRM/SIB Operand Forms

This block takes the bytes that follow an opcode and works out where the operand lives. It reads a ModRM byte. In 32-bit addressing it may then read a SIB byte. It then reads up to four displacement bytes. When every byte of the form has been consumed, it reports the following:

- the register field;
- whether the second operand is a register or memory;
- the second register number;
- the effective address;
- the segment the access uses.

A controller pulses `start` with the addressing size, the segment-override status and a snapshot of the eight general registers. The decoder latches all of these. It then pulls bytes over a valid/ready interface, one byte per accepted handshake. Results are held stable from `done` until the next `start`.

Control is a single state machine with five states:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for `start`. |
| `ST_MODRM` | Accepts the first byte. |
| `ST_SIB` | Accepts the scale/index/base byte. |
| `ST_DISP` | Accepts displacement bytes, lowest byte first. |
| `ST_DONE` | Raises `done` for one cycle. |

The transitions are:

- IDLE→MODRM on `start`.
- MODRM→DONE for the register form or a form without displacement.
- MODRM→SIB when 32-bit addressing has rm = 4.
- MODRM→DISP when a displacement follows.
- SIB→DISP or SIB→DONE, depending on the displacement length.
- DISP→DONE on the last displacement byte.
- DONE→IDLE unconditionally.

Register numbering everywhere is:

| Number | Register |
|---|---|
| 0 | AX |
| 1 | CX |
| 2 | DX |
| 3 | BX |
| 4 | SP |
| 5 | BP |
| 6 | SI |
| 7 | DI |

The snapshot holds register n in bits [32n+31:32n].

Top module: `ea_decoder`

## Requirements
- R1: The first byte splits into mod (bits 7:6), reg (5:3) and rm (2:0). When mod is 3, `is_mem` is 0, `rm_reg` equals rm, `eff_addr` is 0, and no further byte is fetched.
- R2: With 32-bit addressing and rm = 4 (mod not 3), one SIB byte is fetched. The address is base + index × 2^scale, where scale is SIB bits 7:6, index is SIB bits 5:3 and base is SIB bits 2:0. An index of 4 contributes nothing.
- R3: A SIB base of 5 with mod 0 uses a 32-bit displacement in place of the base register. A SIB base of 4 selects SS by default.
- R4: With 32-bit addressing and rm = 5, mod 0 gives a displacement-only address from 4 bytes. A nonzero mod uses BP and selects SS by default.
- R5: Mod 1 adds a sign-extended 8-bit displacement. Mod 2 adds a 32-bit displacement in 32-bit addressing, or a sign-extended 16-bit displacement in 16-bit addressing. Multi-byte displacements arrive lowest byte first.
- R6: In 16-bit addressing, rm 0..7 select the following bases, summed from the low 16 bits of each register: BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. The one exception is rm 6 with mod 0, which takes a 16-bit displacement alone.
- R7: In 16-bit addressing, rm 2 and 3, and rm 6 with nonzero mod, select SS by default. `eff_addr` bits 31:16 are always 0.
- R8: `seg_sel` is chosen in this order:
  - If an override was latched, `seg_sel` is `seg_ovr_idx`.
  - Otherwise, if the form selects SS by default, `seg_sel` is 2 (SS).
  - Otherwise `seg_sel` is 3 (DS).
- R9: The byte-register outputs are derived as follows: `reg8_idx` = reg bits 1:0, `reg8_hi` = reg bit 2, `rm8_idx` = rm bits 1:0 and `rm8_hi` = rm bit 2. Bit 2 set means the high byte.
- R10: `byte_ready` is high only while a byte is awaited. A byte is consumed on each edge where `byte_valid` and `byte_ready` are both high, and stalls change nothing. `done` is high for exactly the one cycle after the last byte is consumed. Results stay stable after `done` until the next `start`.
- R11: After reset, `byte_ready` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode (accepted in ST_IDLE) |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| seg_ovr_valid | input | 1 | An explicit segment override is present |
| seg_ovr_idx | input | 3 | Override segment number |
| reg_snapshot | input | 256 | Eight 32-bit general registers |
| byte_valid | input | 1 | Instruction byte available |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Decoder accepts a byte this cycle |
| done | output | 1 | One-cycle completion pulse |
| reg_field | output | 3 | ModRM reg field |
| is_mem | output | 1 | Second operand is in memory |
| rm_reg | output | 3 | ModRM rm field (second register) |
| eff_addr | output | 32 | Effective address |
| seg_sel | output | 3 | Segment used (2 = SS, 3 = DS, or override) |
| reg8_idx | output | 2 | Byte-register row for reg |
| reg8_hi | output | 1 | reg names a high byte |
| rm8_idx | output | 2 | Byte-register row for rm |
| rm8_hi | output | 1 | rm names a high byte |

## Verification

Every first byte is swept in both addressing sizes, which covers all the rm rows and all displacement lengths. The register snapshot has low halves whose 16-bit sums overflow, so the 16-bit masking is visible. Displacement bytes with the top bit set separate sign extension from zero extension.

A second sweep covers all 256 SIB bytes under each memory mod. This separates the "no index" code, the scaling, the displacement-as-base case and the SS-from-SP-base default. Passes with and without a segment override show that the override beats the SS default. Stalled valid cycles show that idle cycles consume nothing. Counting the accepted handshakes separates correct form lengths from over-fetch or under-fetch.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;

    localparam int REG_W    = 32;
    localparam int NREG     = 8;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int DISP_MAX = 4;
    localparam int LEN_W    = $clog2(DISP_MAX + 1);
    localparam int SEG_W    = 3;

    localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
    localparam logic [SEG_W-1:0] SEG_DS = 3'd3;

    localparam logic [RIDX_W-1:0] RN_BX = 3'd3;
    localparam logic [RIDX_W-1:0] RN_SP = 3'd4;
    localparam logic [RIDX_W-1:0] RN_BP = 3'd5;
    localparam logic [RIDX_W-1:0] RN_SI = 3'd6;
    localparam logic [RIDX_W-1:0] RN_DI = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODRM,
        ST_SIB,
        ST_DISP,
        ST_DONE
    } ea_state_e;

    // Number of displacement bytes implied by the addressing form.
    function automatic logic [LEN_W-1:0] disp_len_f(
        input logic       a32,
        input logic [1:0] md,
        input logic [2:0] rm,
        input logic [2:0] sb
    );
        logic [LEN_W-1:0] n;
        n = '0;
        if (md == 2'd1) begin
            n = LEN_W'(1);
        end else if (md == 2'd2) begin
            n = a32 ? LEN_W'(4) : LEN_W'(2);
        end else if (md == 2'd0) begin
            if (a32) begin
                if (rm == 3'd5 || (rm == 3'd4 && sb == 3'd5)) n = LEN_W'(4);
            end else begin
                if (rm == 3'd6) n = LEN_W'(2);
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/ea_seq.sv
`timescale 1ns/1ps
module ea_seq
    import ea_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    addr32,
    input  logic                    ovr_valid,
    input  logic [SEG_W-1:0]        ovr_idx,
    input  logic [NREG*REG_W-1:0]   regs_in,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_data,
    output logic                    byte_ready,
    output logic                    done,
    output logic                    a32_q,
    output logic                    ovr_valid_q,
    output logic [SEG_W-1:0]        ovr_idx_q,
    output logic [NREG*REG_W-1:0]   regs_q,
    output logic [7:0]              modrm_q,
    output logic [7:0]              sib_q,
    output logic [8*DISP_MAX-1:0]   disp_q,
    output logic [LEN_W-1:0]        disp_len_q
);

    ea_state_e        state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_now;
    logic             take;
    logic             last_disp;
    logic [1:0]       md_src;
    logic [2:0]       rm_src;

    assign take      = byte_valid && byte_ready;
    assign last_disp = (cnt_q == disp_len_q - LEN_W'(1));

    // In ST_MODRM the incoming byte is the ModRM; otherwise it is the latched one.
    always_comb begin
        if (state_q == ST_MODRM) begin
            md_src = byte_data[7:6];
            rm_src = byte_data[2:0];
        end else begin
            md_src = modrm_q[7:6];
            rm_src = modrm_q[2:0];
        end
        len_now = disp_len_f(a32_q, md_src, rm_src, byte_data[2:0]);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_MODRM;
            ST_MODRM: if (take) begin
                if (byte_data[7:6] == 2'b11)                 state_d = ST_DONE;
                else if (a32_q && byte_data[2:0] == 3'd4)    state_d = ST_SIB;
                else if (len_now != '0)                      state_d = ST_DISP;
                else                                         state_d = ST_DONE;
            end
            ST_SIB:   if (take) state_d = (len_now != '0) ? ST_DISP : ST_DONE;
            ST_DISP:  if (take && last_disp) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        byte_ready = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_MODRM: byte_ready = 1'b1;
            ST_SIB:   byte_ready = 1'b1;
            ST_DISP:  byte_ready = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // Context and byte capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a32_q       <= 1'b0;
            ovr_valid_q <= 1'b0;
            ovr_idx_q   <= '0;
            regs_q      <= '0;
            modrm_q     <= '0;
            sib_q       <= '0;
            disp_q      <= '0;
            disp_len_q  <= '0;
            cnt_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    a32_q       <= addr32;
                    ovr_valid_q <= ovr_valid;
                    ovr_idx_q   <= ovr_idx;
                    regs_q      <= regs_in;
                    modrm_q     <= '0;
                    sib_q       <= '0;
                    disp_q      <= '0;
                    disp_len_q  <= '0;
                    cnt_q       <= '0;
                end
                ST_MODRM: if (take) begin
                    modrm_q <= byte_data;
                    if (byte_data[7:6] != 2'b11 && !(a32_q && byte_data[2:0] == 3'd4))
                        disp_len_q <= len_now;
                end
                ST_SIB: if (take) begin
                    sib_q      <= byte_data;
                    disp_len_q <= len_now;
                end
                ST_DISP: if (take) begin
                    disp_q[8*cnt_q +: 8] <= byte_data;
                    cnt_q                <= cnt_q + LEN_W'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
    AST_DONE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_valid && byte_ready));  // R10
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && !byte_valid) |=> ($stable(modrm_q) && $stable(sib_q) && $stable(disp_q)));  // R10
    AST_REG_FORM_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && modrm_q[7:6] == 2'b11) |-> ($past(state_q) == ST_MODRM));  // R1

endmodule

// File: rtl/ea_addr_gen.sv
`timescale 1ns/1ps
module ea_addr_gen
    import ea_pkg::*;
(
    input  logic                   a32,
    input  logic [1:0]             md,
    input  logic [2:0]             rm,
    input  logic [7:0]             sib,
    input  logic [8*DISP_MAX-1:0]  disp,
    input  logic [LEN_W-1:0]       disp_len,
    input  logic [NREG*REG_W-1:0]  regs,
    output logic [REG_W-1:0]       ea,
    output logic                   ss_dflt,
    output logic                   is_mem
);

    logic [REG_W-1:0] r   [NREG];
    logic [REG_W-1:0] w16 [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign r[g]   = regs[g*REG_W +: REG_W];
        assign w16[g] = {{(REG_W-16){1'b0}}, r[g][15:0]};
    end

    logic [REG_W-1:0] disp_sx;
    logic [REG_W-1:0] base_v;
    logic [REG_W-1:0] index_v;
    logic [REG_W-1:0] sum16;

    always_comb begin
        unique case (disp_len)
            LEN_W'(1): disp_sx = {{(REG_W-8){disp[7]}},   disp[7:0]};
            LEN_W'(2): disp_sx = {{(REG_W-16){disp[15]}}, disp[15:0]};
            default:   disp_sx = disp[REG_W-1:0];
        endcase
    end

    always_comb begin
        ea      = '0;
        ss_dflt = 1'b0;
        is_mem  = (md != 2'd3);
        base_v  = '0;
        index_v = '0;
        sum16   = '0;
        if (md == 2'd3) begin
            ea = '0;
        end else if (a32) begin
            if (rm == RN_SP) begin
                base_v  = (sib[2:0] == RN_BP && md == 2'd0) ? '0 : r[sib[2:0]];
                index_v = (sib[5:3] == RN_SP) ? '0 : (r[sib[5:3]] << sib[7:6]);
                ea      = base_v + index_v + disp_sx;
                ss_dflt = (sib[2:0] == RN_SP);
            end else if (rm == RN_BP && md == 2'd0) begin
                ea = disp_sx;
            end else begin
                ea      = r[rm] + disp_sx;
                ss_dflt = (rm == RN_BP);
            end
        end else begin
            unique case (rm)
                3'd0: base_v = w16[RN_BX] + w16[RN_SI];
                3'd1: base_v = w16[RN_BX] + w16[RN_DI];
                3'd2: base_v = w16[RN_BP] + w16[RN_SI];
                3'd3: base_v = w16[RN_BP] + w16[RN_DI];
                3'd4: base_v = w16[RN_SI];
                3'd5: base_v = w16[RN_DI];
                3'd6: base_v = (md == 2'd0) ? '0 : w16[RN_BP];
                3'd7: base_v = w16[RN_BX];
                default: base_v = '0;
            endcase
            sum16   = base_v + disp_sx;
            ea      = {{(REG_W-16){1'b0}}, sum16[15:0]};
            ss_dflt = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'd0);
        end
    end

endmodule

// File: rtl/ea_seg_pick.sv
`timescale 1ns/1ps
module ea_seg_pick
    import ea_pkg::*;
(
    input  logic             ovr_valid,
    input  logic [SEG_W-1:0] ovr_idx,
    input  logic             ss_dflt,
    output logic [SEG_W-1:0] seg
);

    always_comb begin
        if (ovr_valid)    seg = ovr_idx;
        else if (ss_dflt) seg = SEG_SS;
        else              seg = SEG_DS;
    end

endmodule

// File: rtl/ea_decoder.sv
`timescale 1ns/1ps
module ea_decoder
    import ea_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   addr32,
    input  logic                   seg_ovr_valid,
    input  logic [2:0]             seg_ovr_idx,
    input  logic [255:0]           reg_snapshot,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_data,
    output logic                   byte_ready,
    output logic                   done,
    output logic [2:0]             reg_field,
    output logic                   is_mem,
    output logic [2:0]             rm_reg,
    output logic [31:0]            eff_addr,
    output logic [2:0]             seg_sel,
    output logic [1:0]             reg8_idx,
    output logic                   reg8_hi,
    output logic [1:0]             rm8_idx,
    output logic                   rm8_hi
);

    logic                  a32_q;
    logic                  ovr_valid_q;
    logic [SEG_W-1:0]      ovr_idx_q;
    logic [NREG*REG_W-1:0] regs_q;
    logic [7:0]            modrm_q;
    logic [7:0]            sib_q;
    logic [8*DISP_MAX-1:0] disp_q;
    logic [LEN_W-1:0]      disp_len_q;
    logic                  ss_dflt;

    ea_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .addr32      (addr32),
        .ovr_valid   (seg_ovr_valid),
        .ovr_idx     (seg_ovr_idx),
        .regs_in     (reg_snapshot),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_ready  (byte_ready),
        .done        (done),
        .a32_q       (a32_q),
        .ovr_valid_q (ovr_valid_q),
        .ovr_idx_q   (ovr_idx_q),
        .regs_q      (regs_q),
        .modrm_q     (modrm_q),
        .sib_q       (sib_q),
        .disp_q      (disp_q),
        .disp_len_q  (disp_len_q)
    );

    ea_addr_gen u_addr (
        .a32      (a32_q),
        .md       (modrm_q[7:6]),
        .rm       (modrm_q[2:0]),
        .sib      (sib_q),
        .disp     (disp_q),
        .disp_len (disp_len_q),
        .regs     (regs_q),
        .ea       (eff_addr),
        .ss_dflt  (ss_dflt),
        .is_mem   (is_mem)
    );

    ea_seg_pick u_seg (
        .ovr_valid (ovr_valid_q),
        .ovr_idx   (ovr_idx_q),
        .ss_dflt   (ss_dflt),
        .seg       (seg_sel)
    );

    assign reg_field = modrm_q[5:3];
    assign rm_reg    = modrm_q[2:0];
    assign reg8_idx  = modrm_q[4:3];
    assign reg8_hi   = modrm_q[5];
    assign rm8_idx   = modrm_q[1:0];
    assign rm8_hi    = modrm_q[2];

    AST_ADDR16_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !a32_q) |-> (eff_addr[31:16] == 16'h0));  // R7
    AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovr_valid_q) |-> (seg_sel == ovr_idx_q));  // R8
    AST_REG_FORM_NO_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_mem) |-> (eff_addr == 32'h0));  // R1
    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> ($stable(eff_addr) && $stable(seg_sel)));  // R10

endmodule

// File: tb/ea_decoder_tb.sv
`timescale 1ns/1ps
module ea_decoder_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         addr32 = 1'b0;
    logic         seg_ovr_valid = 1'b0;
    logic [2:0]   seg_ovr_idx = 3'd0;
    logic [255:0] reg_snapshot;
    logic         byte_valid = 1'b0;
    logic [7:0]   byte_data = 8'h0;
    logic         byte_ready, done, is_mem, reg8_hi, rm8_hi;
    logic [2:0]   reg_field, rm_reg, seg_sel;
    logic [31:0]  eff_addr;
    logic [1:0]   reg8_idx, rm8_idx;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] R [8];

    always #2 clk = ~clk;

    initial begin
        R[0] = 32'h1111_8001; R[1] = 32'h2222_4002; R[2] = 32'h3333_C003; R[3] = 32'h4444_F004;
        R[4] = 32'h0000_0FF0; R[5] = 32'h5555_E005; R[6] = 32'h6666_2346; R[7] = 32'h7777_9A07;
    end
    always_comb for (int i = 0; i < 8; i++) reg_snapshot[i*32 +: 32] = R[i];

    ea_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr32(addr32),
        .seg_ovr_valid(seg_ovr_valid), .seg_ovr_idx(seg_ovr_idx), .reg_snapshot(reg_snapshot),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready), .done(done),
        .reg_field(reg_field), .is_mem(is_mem), .rm_reg(rm_reg), .eff_addr(eff_addr),
        .seg_sel(seg_sel), .reg8_idx(reg8_idx), .reg8_hi(reg8_hi), .rm8_idx(rm8_idx), .rm8_hi(rm8_hi)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected behaviour computed from the requirements.
    task automatic model(input bit a32, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3,
                         output int nbytes, output int dl, output logic [31:0] ea, output bit ss,
                         output bit sib_used, output string tag);
        logic [1:0]  md;
        logic [2:0]  rm;
        logic [31:0] dv, b, ix, sum;
        md = m[7:6]; rm = m[2:0];
        dl = 0; ea = 0; ss = 0; sib_used = 0; dv = 0; tag = "R5";
        if (md == 2'd3) begin
            tag = "R1";
        end else if (a32) begin
            sib_used = (rm == 3'd4);
            if (md == 2'd1) dl = 1;
            else if (md == 2'd2) dl = 4;
            else if (rm == 3'd5 || (rm == 3'd4 && s[2:0] == 3'd5)) dl = 4;
            if (dl == 1) dv = {{24{d0[7]}}, d0};
            else if (dl == 4) dv = {d3, d2, d1, d0};
            if (rm == 3'd4) begin
                b  = (s[2:0] == 3'd5 && md == 2'd0) ? 32'h0 : R[s[2:0]];
                ix = (s[5:3] == 3'd4) ? 32'h0 : R[s[5:3]] * (32'd1 << s[7:6]);
                ea = b + ix + dv;
                ss = (s[2:0] == 3'd4);
                tag = ((s[2:0] == 3'd5 && md == 2'd0) || s[2:0] == 3'd4) ? "R3" : "R2";
            end else if (rm == 3'd5) begin
                ea = (md == 2'd0) ? dv : R[5] + dv;
                ss = (md != 2'd0);
                tag = "R4";
            end else begin
                ea = R[rm] + dv;
            end
        end else begin
            if (md == 2'd1) dl = 1;
            else if (md == 2'd2 || rm == 3'd6) dl = 2;
            if (dl == 1) dv = {{24{d0[7]}}, d0};
            else if (dl == 2) dv = {{16{d1[7]}}, d1, d0};
            case (rm)
                3'd0: sum = R[3][15:0] + R[6][15:0];
                3'd1: sum = R[3][15:0] + R[7][15:0];
                3'd2: sum = R[5][15:0] + R[6][15:0];
                3'd3: sum = R[5][15:0] + R[7][15:0];
                3'd4: sum = {16'h0, R[6][15:0]};
                3'd5: sum = {16'h0, R[7][15:0]};
                3'd6: sum = (md == 2'd0) ? 32'h0 : {16'h0, R[5][15:0]};
                default: sum = {16'h0, R[3][15:0]};
            endcase
            ea = (sum + dv) & 32'h0000_FFFF;
            ss = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'd0);
            tag = ss ? "R7" : "R6";
        end
        nbytes = 1 + (sib_used ? 1 : 0) + dl;
    endtask

    task automatic run(input bit a32, input logic [7:0] m, input logic [7:0] s,
                       input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3,
                       input bit ov, input logic [2:0] oi, input bit gap);
        int nbytes, dl, k, cyc;
        logic [31:0] ea;
        bit ss, sib_used, got, v;
        string tag;
        logic [7:0] st [6];
        logic [2:0] seg_exp;
        model(a32, m, s, d0, d1, d2, d3, nbytes, dl, ea, ss, sib_used, tag);
        st[0] = m;
        k = 1;
        if (sib_used) begin st[1] = s; k = 2; end
        st[k] = d0; st[k+1] = d1; st[k+2] = d2; st[k+3] = d3;
        @(negedge clk);
        addr32 = a32; seg_ovr_valid = ov; seg_ovr_idx = oi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; cyc = 0; got = 0;
        while (!got && cyc < 40) begin
            if (done) begin
                got = 1;
            end else begin
                v = !(gap && (cyc % 3 == 1));
                byte_valid = v;
                byte_data  = (k < 6) ? st[k] : 8'hEE;
                if (byte_ready && v) k++;
                @(negedge clk);
                cyc++;
            end
        end
        byte_valid = 1'b0;
        chk("R10", "done seen", 32'(got), 32'd1);
        chk(tag, "bytes consumed", k, nbytes);
        chk("R1", "is_mem", 32'(is_mem), 32'(m[7:6] != 2'd3));
        chk("R1", "reg_field", 32'(reg_field), 32'(m[5:3]));
        chk("R1", "rm_reg", 32'(rm_reg), 32'(m[2:0]));
        chk(tag, "eff_addr", eff_addr, ea);
        seg_exp = ov ? oi : (ss ? 3'd2 : 3'd3);
        chk("R8", "seg_sel", 32'(seg_sel), 32'(seg_exp));
        chk("R9", "byte lanes", {24'h0, reg8_hi, reg8_idx, rm8_hi, rm8_idx}, {24'h0, m[5], m[4:3], m[2], m[1:0]});
        @(negedge clk);
        chk("R10", "done single cycle", 32'(done), 32'd0);
        chk("R10", "no fetch after done", 32'(byte_ready), 32'd0);
        chk("R10", "result held", eff_addr, ea);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] mm, ss8;
        repeat (3) @(negedge clk);
        chk("R11", "ready in reset", 32'(byte_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "done after reset", 32'(done), 32'd0);
        chk("R11", "ready after reset", 32'(byte_ready), 32'd0);

        // Sweep every first byte in both addressing sizes.
        for (int a = 0; a < 2; a++) begin
            for (int m = 0; m < 256; m++) begin
                mm  = 8'(m);
                ss8 = mm ^ 8'h5A;
                run(a[0], mm, ss8, 8'(m*7+3), 8'(m*13+128), 8'(m*29+17), 8'(m*3+200), 1'b0, 3'd0, mm[0]);
            end
        end
        // Sweep every SIB byte under each memory mod.
        for (int md = 0; md < 3; md++) begin
            for (int s = 0; s < 256; s++) begin
                mm = {2'(md), 3'(s), 3'd4};
                run(1'b1, mm, 8'(s), 8'(s*11+5), 8'(s*5+130), 8'(s+64), 8'(255-s), 1'b0, 3'd0, 1'(s >> 1));
            end
        end
        // Overrides against every row, both sizes.
        for (int a = 0; a < 2; a++) begin
            for (int md = 0; md < 4; md++) begin
                for (int rm = 0; rm < 8; rm++) begin
                    for (int oi = 0; oi < 6; oi++) begin
                        mm = {2'(md), 3'(oi), 3'(rm)};
                        run(a[0], mm, 8'h24, 8'h90, 8'hFE, 8'h01, 8'h80, 1'b1, 3'(oi), 1'b0);
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule